// File: doc/BRIEF.md
# Byte-Lane Synchronous RAM Port

This block is one clocked port onto a small on-chip RAM. Each word is 64 bits wide and is split into eight 8-bit lanes. The port acts on a rising clock edge only when both of its selects agree: `sel_n` is low and `sel` is high. A direction line picks a read or a write, and a per-lane active-low mask picks which lanes take part. There are two asynchronous controls, an output enable and a sleep input. Each one can silence every lane at once. The port has no tristate pins. Instead, a lane-valid vector marks which lanes carry read data, and every lane that is not driven reads as zero on `rdata`.

The read path has two modes. In flow-through mode the read data appears after one register. In pipelined mode it passes a second register and appears one cycle later. The mode input is taken at reset and at idle edges only. Sleep freezes the read registers. Once sleep or the output enable is released, the held data shows again.

Top module: `bytelane_sram_port`

## Requirements
- R1: An access takes place only when `sel_n`=0 and `sel`=1 at a rising edge. Any other pair writes nothing, and no lane is valid in the cycle after that edge.
- R2: Each bit of `lane_en_n` is active low, and bit i controls bits [8i+7:8i] of the word. Any mix of lanes can take part in one access.
- R3: If the port is selected and `lane_en_n` is all ones, no lane is written and no lane is valid afterwards.
- R4: A selected edge with `rd_wr`=0 writes `wdata` into the enabled lanes only. Every other lane keeps its stored byte.
- R5: A selected edge with `rd_wr`=1 makes valid exactly the enabled lanes, each with its stored byte. Lanes that are not valid read 0 on `rdata`.
- R6: While `oe_n`=1, `lane_oe` and `rdata` are all zero in the same cycle. Reads are still captured, and they show as soon as `oe_n` returns to 0.
- R7: While `sleep`=1, `lane_oe` and `rdata` are zero in the same cycle, no access happens at the edge, and the read registers hold. Their contents show again once `sleep` is 0.
- R8: With flow-through mode (`pipe_mode`=0), read data is valid in the cycle right after the read edge. With pipelined mode (`pipe_mode`=1), it is valid one cycle later.
- R9: `pipe_mode` is loaded at reset and at edges with no access and no sleep. At an access edge, the latency in use does not change.
- R10: During and right after reset, `lane_oe` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Select, active low |
| sel | input | 1 | Select, active high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| lane_en_n | input | 8 | Per-lane enable, active low |
| addr | input | 6 | Word address |
| wdata | input | 64 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| pipe_mode | input | 1 | 1 = pipelined read, 0 = flow-through |
| rdata | output | 64 | Read data, zero in undriven lanes |
| lane_oe | output | 8 | Per-lane valid (driven) flags |

## Verification
Suppose a lane mask is decoded wrongly or a select is misread. Then a wrong byte shows in `lane_oe` and `rdata` in the cycle after the faulty edge, or, for writes, at the first read-back. If the second register shifts wrongly, or the mode register loads at a busy edge, the latency is off by one cycle. That shows on the next read. A sleep freeze that leaks, or a gate that is missed, shows at once when sleep or `oe_n` changes, because both act without a clock.

// File: rtl/sramport_pkg.sv
// Shared types for the byte-lane RAM port.
package sramport_pkg;
    // Kind of operation decided at a clock edge.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;
endpackage

// File: rtl/sram_access_decode.sv
// Turns the two selects, the direction line and sleep into one access kind.
// Assumes every input is stable around the rising edge. Sleep wins over all.
module sram_access_decode
    import sramport_pkg::*;
(
    input  logic sel_n,
    input  logic sel,
    input  logic rd_wr,
    input  logic sleep,
    output acc_e acc
);
    // Purpose: the port acts only when both selects agree and sleep is low.
    always_comb begin
        acc = ACC_IDLE;
        if (!sleep && !sel_n && sel) begin
            acc = rd_wr ? ACC_READ : ACC_WRITE;
        end
    end
endmodule

// File: rtl/sram_lane_array.sv
// Storage: one memory per byte lane, written under the lane mask.
// The read is combinational at addr, and the output stage registers it.
// The array is not reset, so a lane that was never written reads unknown.
module sram_lane_array
    import sramport_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  acc_e              acc,
    input  logic [LANES-1:0]  lane_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ram_word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Purpose: write this lane only if it is enabled in a write access.
        always_ff @(posedge clk) begin
            if (acc == ACC_WRITE && !lane_en_n[g]) begin
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign ram_word[g*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/sram_out_stage.sv
// Read path: a capture register (flow-through), then a second register
// (pipelined). A mode register picks which one is shown. Output enable
// and sleep gate the lanes without a clock. Sleep freezes both registers.
// Assumes acc is already IDLE whenever sleep is high.
module sram_out_stage
    import sramport_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              acc,
    input  logic [LANES-1:0]  lane_en_n,
    input  logic [WORD_W-1:0] ram_word,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic              pipe_mode,
    output logic [WORD_W-1:0] rdata,
    output logic [LANES-1:0]  lane_oe
);
    logic [LANES-1:0]  vld_a, vld_b;
    logic [WORD_W-1:0] dat_a, dat_b;
    logic [WORD_W-1:0] masked_word;
    logic [LANES-1:0]  shown_vld;
    logic [WORD_W-1:0] shown_dat;
    logic              mode_q;
    logic              ungated;

    // Purpose: zero the lanes that the read does not enable.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            masked_word[i*LANE_W +: LANE_W] =
                lane_en_n[i] ? '0 : ram_word[i*LANE_W +: LANE_W];
        end
    end

    // Purpose: capture, shift and mode load; everything holds during sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_a  <= '0;
            vld_b  <= '0;
            dat_a  <= '0;
            dat_b  <= '0;
            mode_q <= pipe_mode;
        end else if (!sleep) begin
            vld_a <= (acc == ACC_READ) ? ~lane_en_n : '0;
            dat_a <= (acc == ACC_READ) ? masked_word : '0;
            vld_b <= vld_a;
            dat_b <= dat_a;
            if (acc == ACC_IDLE) begin
                mode_q <= pipe_mode;
            end
        end
    end

    assign shown_vld = mode_q ? vld_b : vld_a;
    assign shown_dat = mode_q ? dat_b : dat_a;
    assign ungated   = !(oe_n || sleep);
    assign lane_oe   = shown_vld & {LANES{ungated}};

    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign rdata[g*LANE_W +: LANE_W] =
            lane_oe[g] ? shown_dat[g*LANE_W +: LANE_W] : '0;
    end

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != ACC_READ && !sleep) |=> (vld_a == '0)); // R1
    AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_READ) |=> (vld_a == ~$past(lane_en_n))); // R5
    AST_PIPE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep) |=> (vld_b == $past(vld_a) && dat_b == $past(dat_a))); // R8
    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(vld_a) && $stable(vld_b) && $stable(mode_q))); // R7
    AST_GATED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || sleep) |-> (rdata == '0)); // R6
    AST_MODE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != ACC_IDLE) |=> $stable(mode_q)); // R9
endmodule

// File: rtl/bytelane_sram_port.sv
// Top: one synchronous port with per-byte-lane writes and reads, gating
// without a clock, and a selectable flow-through or pipelined read path.
// Assumes synchronous inputs meet setup at the rising edge. oe_n and sleep
// may change at any time.
module bytelane_sram_port
    import sramport_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_n,
    input  logic                       sel,
    input  logic                       rd_wr,
    input  logic [LANES-1:0]           lane_en_n,
    input  logic [$clog2(DEPTH)-1:0]   addr,
    input  logic [LANES*LANE_W-1:0]    wdata,
    input  logic                       oe_n,
    input  logic                       sleep,
    input  logic                       pipe_mode,
    output logic [LANES*LANE_W-1:0]    rdata,
    output logic [LANES-1:0]           lane_oe
);
    localparam int WORD_W = LANES * LANE_W;

    acc_e              acc;
    logic [WORD_W-1:0] ram_word;

    sram_access_decode u_dec (
        .sel_n (sel_n),
        .sel   (sel),
        .rd_wr (rd_wr),
        .sleep (sleep),
        .acc   (acc)
    );

    sram_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_arr (
        .clk       (clk),
        .acc       (acc),
        .lane_en_n (lane_en_n),
        .addr      (addr),
        .wdata     (wdata),
        .ram_word  (ram_word)
    );

    sram_out_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .lane_en_n (lane_en_n),
        .ram_word  (ram_word),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .pipe_mode (pipe_mode),
        .rdata     (rdata),
        .lane_oe   (lane_oe)
    );
endmodule

// File: tb/sim_bytelane_sram_port.sv
// Bench: a table walked in flow-through mode, then directed tests for
// reset, gating, sleep, pipelined latency and when the mode is loaded.
module sim_bytelane_sram_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_n, sel, rd_wr, oe_n, sleep, pipe_mode;
    logic [7:0]  lane_en_n;
    logic [5:0]  addr;
    logic [63:0] wdata;
    logic [63:0] rdata;
    logic [7:0]  lane_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [63:0] W3 = 64'h11223344DDDDDDDD;

    always #4 clk = ~clk;

    bytelane_sram_port u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .rd_wr(rd_wr),
        .lane_en_n(lane_en_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
        .sleep(sleep), .pipe_mode(pipe_mode), .rdata(rdata), .lane_oe(lane_oe)
    );

    // Fields: req[156:153] sel_n[152] sel[151] rd_wr[150] en_n[149:142]
    //         addr[141:136] wdata[135:72] exp_oe[71:64] exp_data[63:0]
    localparam int NV = 14;
    localparam logic [156:0] VEC [NV] = '{
        {4'd4,  3'b010, 8'h00, 6'd3,  64'h1122334455667788, 8'h00, 64'h0},                   // R4 full write
        {4'd5,  3'b011, 8'h00, 6'd3,  64'h0,                8'hFF, 64'h1122334455667788},    // R5 full read
        {4'd4,  3'b010, 8'hF0, 6'd3,  64'hCCCCCCCCDDDDDDDD, 8'h00, 64'h0},                   // R4 low lanes
        {4'd4,  3'b011, 8'h00, 6'd3,  64'h0,                8'hFF, W3},                      // R4 upper kept
        {4'd2,  3'b011, 8'h5A, 6'd3,  64'h0,                8'hA5, 64'h1100330000DD00DD},    // R2 sparse read
        {4'd1,  3'b111, 8'h00, 6'd3,  64'h0,                8'h00, 64'h0},                   // R1 sel_n high
        {4'd1,  3'b000, 8'h00, 6'd3,  64'hFFFFFFFFFFFFFFFF, 8'h00, 64'h0},                   // R1 sel low
        {4'd1,  3'b100, 8'h00, 6'd3,  64'h0,                8'h00, 64'h0},                   // R1 both off
        {4'd1,  3'b011, 8'h00, 6'd3,  64'h0,                8'hFF, W3},                      // R1 no write
        {4'd3,  3'b010, 8'hFF, 6'd3,  64'h0,                8'h00, 64'h0},                   // R3 empty write
        {4'd3,  3'b011, 8'hFF, 6'd3,  64'h0,                8'h00, 64'h0},                   // R3 empty read
        {4'd3,  3'b011, 8'h00, 6'd3,  64'h0,                8'hFF, W3},                      // R3 word intact
        {4'd4,  3'b010, 8'h7E, 6'd63, 64'h0102030405060708, 8'h00, 64'h0},                   // R4 edge lanes
        {4'd2,  3'b011, 8'h7E, 6'd63, 64'h0,                8'h81, 64'h0100000000000008}     // R2 edge lanes
    };

    task automatic drive(input logic sn, input logic s, input logic rw,
                         input logic [7:0] en, input logic [5:0] a,
                         input logic [63:0] wd);
        sel_n = sn; sel = s; rd_wr = rw; lane_en_n = en; addr = a; wdata = wd;
    endtask

    task automatic idle();
        drive(1'b1, 1'b0, 1'b1, 8'hFF, 6'd0, 64'h0);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] eo,
                         input logic [63:0] ed);
        checks++;
        if (lane_oe !== eo || rdata !== ed) begin
            fails++;
            $display("FAIL %s: lane_oe=%h rdata=%h expected lane_oe=%h rdata=%h",
                     tag, lane_oe, rdata, eo, ed);
        end
    endtask

    initial begin
        rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0; pipe_mode = 1'b0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 in reset", 8'h00, 64'h0);
        rst_n = 1'b1;
        step();
        check("R10 after reset", 8'h00, 64'h0);

        // Table, flow-through mode: output valid right after each edge (R8).
        for (int i = 0; i < NV; i++) begin
            logic [156:0] v;
            v = VEC[i];
            drive(v[152], v[151], v[150], v[149:142], v[141:136], v[135:72]);
            step();
            checks++;
            if (lane_oe !== v[71:64] || rdata !== v[63:0]) begin
                fails++;
                $display("FAIL R%0d vector %0d: lane_oe=%h rdata=%h expected lane_oe=%h rdata=%h",
                         v[156:153], i, lane_oe, rdata, v[71:64], v[63:0]);
            end
        end

        // R6: read captured under oe_n high, appears on release
        drive(1'b0, 1'b1, 1'b1, 8'h00, 6'd3, 64'h0);
        oe_n = 1'b1;
        step();
        check("R6 gated", 8'h00, 64'h0);
        oe_n = 1'b0;
        #1 check("R6 released", 8'hFF, W3);
        idle();
        step();
        check("R8 flow one cycle", 8'h00, 64'h0);

        // R7: sleep gates at once, blocks a write, keeps read data
        drive(1'b0, 1'b1, 1'b1, 8'h00, 6'd3, 64'h0);
        step();
        check("R8 flow read", 8'hFF, W3);
        sleep = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 8'h00, 6'd3, 64'h0);
        #1 check("R7 sleep gate", 8'h00, 64'h0);
        step();
        check("R7 sleep over edge", 8'h00, 64'h0);
        sleep = 1'b0;
        idle();
        #1 check("R7 held data", 8'hFF, W3);
        step();
        drive(1'b0, 1'b1, 1'b1, 8'h00, 6'd3, 64'h0);
        step();
        check("R7 write blocked", 8'hFF, W3);

        // R8: pipelined mode adds one cycle
        idle();
        pipe_mode = 1'b1;
        step();
        step();
        check("R8 pipe idle", 8'h00, 64'h0);
        drive(1'b0, 1'b1, 1'b1, 8'hFE, 6'd3, 64'h0);
        step();
        check("R8 pipe first cycle", 8'h00, 64'h0);
        idle();
        step();
        check("R8 pipe delayed", 8'h01, 64'h00000000000000DD);
        step();
        check("R8 pipe done", 8'h00, 64'h0);

        // R9: mode change at an access edge waits for an idle edge
        drive(1'b0, 1'b1, 1'b1, 8'h00, 6'd3, 64'h0);
        pipe_mode = 1'b0;
        step();
        check("R9 mode held", 8'h00, 64'h0);
        idle();
        step();
        check("R9 flow after idle", 8'h00, 64'h0);
        drive(1'b0, 1'b1, 1'b1, 8'h00, 6'd3, 64'h0);
        step();
        check("R9 flow active", 8'hFF, W3);

        idle();
        step();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule